// File: doc/BRIEF.md
# Register-Configured LED Blinker

This block holds one configuration register per LED for four LED outputs and turns each register into a steady or flashing drive level. Each LED can be held dark, held lit, or made to flash with a half-period counted in ticks of a shared timebase. A free-running divider derives that timebase from the system clock; its rate is fixed by two parameters, the clock frequency and the tick frequency.

A Wishbone slave port gives access to the four registers. It answers every request exactly one cycle later, and a read returns the word most recently written to that register. An output-polarity parameter sets the drive level for a lit LED, so the same block can drive LEDs wired either way.

Top module: `led_blink_bank`

## Requirements
- R1: After reset all four registers read 0, every LED is dark and the acknowledge output is low.
- R2: The word address `wb_adr_i` selects the LED register (0 to 3). Bits [1:0] of a register set the mode: 00 dark, 01 lit, 10 flashing, and 11 behaves as dark.
- R3: In mode 01 the LED is lit continuously. In mode 00 it is dark continuously.
- R4: In flashing mode, with half-period H in bits [15:8], the LED changes state once every H ticks. A full flash cycle is therefore 2·H ticks.
- R5: A half-period field of 0 acts like a half-period of 1.
- R6: A write that changes an LED's mode clears that LED's tick count and starts it dark. In flashing mode, the first change then follows H ticks after the write.
- R7: One tick occurs every CLK_HZ/TICK_HZ clock cycles, and each tick lasts a single cycle.
- R8: With ACTIVE_HIGH=1 a lit LED drives 1. With ACTIVE_HIGH=0 a lit LED drives 0 and a dark LED drives 1.
- R9: For a request, `wb_ack_o` goes high in the cycle after `wb_cyc_i` and `wb_stb_i` are sampled high, and stays high for one cycle only.
- R10: A read returns the full data word most recently written to the addressed register.
- R11: A write to one LED's register changes neither the output nor the register contents of any other LED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Transfer strobe |
| wb_we_i | input | 1 | 1 for write, 0 for read |
| wb_adr_i | input | ADDR_W (2) | Register (LED) index |
| wb_dat_i | input | DATA_W (32) | Write data |
| wb_dat_o | output | DATA_W (32) | Read data, valid with acknowledge |
| wb_ack_o | output | 1 | Transfer acknowledge |
| led_o | output | LED_COUNT (4) | LED drive levels after polarity |

## Verification
The assertions rely on the bus master keeping `wb_cyc_i` and `wb_stb_i` low while reset is active. The bus checks also assume each request either drops after its acknowledge or is presented again. The stimulus meets both conditions: every task raises a request on a falling edge, holds it until it sees the acknowledge, and then drops it for at least one cycle. Flash timing is measured only at the LED pins. The bench allows for the unknown phase of the free-running tick by accepting a window of four cycles for the first change after a write. It requires exact cycle counts between later changes.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
   typedef enum logic [1:0] {
      MODE_DARK  = 2'b00,
      MODE_LIT   = 2'b01,
      MODE_FLASH = 2'b10,
      MODE_SPARE = 2'b11
   } led_mode_e;

   localparam int MODE_LSB = 0;
   localparam int HALF_LSB = 8;
   localparam int HALF_W   = 8;
   localparam int CFG_MIN_W = HALF_LSB + HALF_W;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
   parameter int CLK_HZ  = 100_000_000,
   parameter int TICK_HZ = 1000
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   localparam int DIV = CLK_HZ / TICK_HZ;
   localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;

   if (TICK_HZ <= 0 || CLK_HZ < TICK_HZ) begin : g_bad_rate
      $error("tick_divider: TICK_HZ must be positive and not above CLK_HZ");
   end

   if (DIV <= 1) begin : g_every_cycle
      logic unused_ok;
      assign unused_ok = clk ^ rst;
      assign tick_o = 1'b1;
   end else begin : g_counter
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or posedge rst) begin
         if (rst) cnt <= '0;
         else if (cnt == CW'(DIV - 1)) cnt <= '0;
         else cnt <= cnt + 1'b1;
      end
      assign tick_o = (cnt == CW'(DIV - 1));

      // R7
      tick_single_chk: assert property (@(posedge clk) disable iff (rst)
         tick_o |=> !tick_o);
   end
endmodule

// File: rtl/led_channel.sv
module led_channel
   import led_blink_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] cfg_o,
   output logic              led_o
);
   if (DATA_W < CFG_MIN_W) begin : g_bad_width
      $error("led_channel: DATA_W too narrow for the half-period field");
   end

   logic [DATA_W-1:0] cfg;
   logic [HALF_W-1:0] cnt;
   logic              lit;
   led_mode_e         mode;
   logic [HALF_W-1:0] half, eff_half;
   logic              restart, last, active;

   assign mode     = led_mode_e'(cfg[MODE_LSB +: 2]);
   assign half     = cfg[HALF_LSB +: HALF_W];
   assign eff_half = (half == '0) ? HALF_W'(1) : half;
   assign last     = (cnt >= eff_half - HALF_W'(1));
   assign restart  = wr_i && (wdata_i[MODE_LSB +: 2] != cfg[MODE_LSB +: 2]);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cfg <= '0;
         cnt <= '0;
         lit <= 1'b0;
      end else begin
         if (wr_i) cfg <= wdata_i;
         if (restart) begin
            cnt <= '0;
            lit <= 1'b0;
         end else if (mode == MODE_FLASH && tick_i) begin
            if (last) begin
               cnt <= '0;
               lit <= ~lit;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign active = (mode == MODE_LIT) || (mode == MODE_FLASH && lit);
   assign cfg_o  = cfg;

   if (ACTIVE_HIGH) begin : g_drive_high
      assign led_o = active;
   end else begin : g_drive_low
      assign led_o = ~active;
   end

   // R4
   flash_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
      (!$stable(lit) && !$past(wr_i)) |-> ($past(tick_i) && $past(mode) == MODE_FLASH));

   // R6
   restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(restart) |-> (cnt == '0 && !lit));
endmodule

// File: rtl/led_blink_bank.sv
module led_blink_bank
   import led_blink_pkg::*;
#(
   parameter int CLK_HZ      = 100_000_000,
   parameter int TICK_HZ     = 1000,
   parameter bit ACTIVE_HIGH = 1'b1,
   parameter int LED_COUNT   = 4,
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wb_cyc_i,
   input  logic                 wb_stb_i,
   input  logic                 wb_we_i,
   input  logic [ADDR_W-1:0]    wb_adr_i,
   input  logic [DATA_W-1:0]    wb_dat_i,
   output logic [DATA_W-1:0]    wb_dat_o,
   output logic                 wb_ack_o,
   output logic [LED_COUNT-1:0] led_o
);
   if (LED_COUNT != 4) begin : g_bad_count
      $error("led_blink_bank: exactly four LEDs are supported");
   end
   if ((1 << ADDR_W) < LED_COUNT) begin : g_bad_addr
      $error("led_blink_bank: ADDR_W cannot reach every LED register");
   end

   logic                 tick;
   logic                 req;
   logic [LED_COUNT-1:0] wr_sel;
   logic [DATA_W-1:0]    cfg_bus [LED_COUNT];
   logic [DATA_W-1:0]    rd_mux;

   assign req = wb_cyc_i && wb_stb_i && !wb_ack_o;

   tick_divider #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
      .clk(clk), .rst(rst), .tick_o(tick)
   );

   for (genvar i = 0; i < LED_COUNT; i++) begin : g_led
      assign wr_sel[i] = req && wb_we_i && (wb_adr_i == ADDR_W'(i));
      led_channel #(.DATA_W(DATA_W), .ACTIVE_HIGH(ACTIVE_HIGH)) u_chan (
         .clk(clk), .rst(rst), .tick_i(tick), .wr_i(wr_sel[i]),
         .wdata_i(wb_dat_i), .cfg_o(cfg_bus[i]), .led_o(led_o[i])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < LED_COUNT; i++) begin
         if (wb_adr_i == ADDR_W'(i)) rd_mux = cfg_bus[i];
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         wb_ack_o <= 1'b0;
         wb_dat_o <= '0;
      end else begin
         wb_ack_o <= req;
         if (req && !wb_we_i) wb_dat_o <= rd_mux;
      end
   end

   // R9
   ack_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);

   // R9
   ack_requested_chk: assert property (@(posedge clk) disable iff (rst)
      wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));

   // R11
   single_write_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wr_sel));
endmodule

// File: tb/led_blink_bank_tb.sv
module led_blink_bank_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [1:0]  adr = '0;
   logic [31:0] wdat = '0;
   logic [31:0] rdat, rdat_lo;
   logic        ack, ack_lo;
   logic [3:0]  led, led_lo;
   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   led_blink_bank #(.CLK_HZ(40), .TICK_HZ(10), .ACTIVE_HIGH(1'b1)) u_dut (
      .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
      .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack), .led_o(led));

   led_blink_bank #(.CLK_HZ(40), .TICK_HZ(10), .ACTIVE_HIGH(1'b0)) u_dut_lo (
      .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
      .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat_lo), .wb_ack_o(ack_lo), .led_o(led_lo));

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wb_write(input logic [1:0] a, input logic [31:0] d);
      int lat;
      @(negedge clk);
      cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
      lat = 0;
      do begin @(negedge clk); lat++; end while (!ack && lat < 10);
      check(lat == 1, "R9", "write ack latency", lat, 1);
      cyc = 0; stb = 0; we = 0;
      @(negedge clk);
      check(ack == 1'b0, "R9", "ack single cycle", ack, 0);
   endtask

   task automatic wb_read(input logic [1:0] a, output logic [31:0] d);
      int lat;
      @(negedge clk);
      cyc = 1; stb = 1; we = 0; adr = a;
      lat = 0;
      do begin @(negedge clk); lat++; end while (!ack && lat < 10);
      check(lat == 1, "R9", "read ack latency", lat, 1);
      d = rdat;
      cyc = 0; stb = 0;
      @(negedge clk);
   endtask

   task automatic wait_toggle(input int idx, input int limit, output int n);
      logic prev;
      prev = led[idx];
      n = 0;
      do begin @(negedge clk); n++; end while (led[idx] == prev && n < limit);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check(led == 4'h0, "R1", "leds dark after reset", led, 0);
      check(led_lo == 4'hF, "R8", "active-low dark after reset", led_lo, 4'hF);
      check(ack == 1'b0, "R1", "ack low after reset", ack, 0);
      for (int i = 0; i < 4; i++) begin
         wb_read(2'(i), d);
         check(d == 32'h0, "R1", "register zero after reset", d, 0);
      end
   endtask

   task automatic t_on_off();
      wb_write(2'd1, 32'h0000_0001);
      check(led == 4'b0010, "R3", "LED1 lit, others dark (R11)", led, 4'b0010);
      check(led_lo == 4'b1101, "R8", "active-low inverted drive", led_lo, 4'b1101);
      wb_write(2'd1, 32'h0000_0003);
      check(led == 4'b0000, "R2", "mode 11 acts as dark", led, 0);
      wb_write(2'd1, 32'h0000_0001);
      wb_write(2'd1, 32'h0000_0000);
      check(led == 4'b0000, "R3", "mode 00 dark", led, 0);
   endtask

   task automatic t_readback();
      logic [31:0] d;
      wb_write(2'd2, 32'hDEAD_5A00);
      wb_read(2'd2, d);
      check(d == 32'hDEAD_5A00, "R10", "readback of last write", d, 32'hDEAD_5A00);
      wb_read(2'd1, d);
      check(d == 32'h0, "R11", "neighbour register untouched", d, 0);
      check(led == 4'h0, "R11", "no LED changed by dark write", led, 0);
   endtask

   task automatic t_flash();
      int n;
      wb_write(2'd0, 32'h0000_0302);
      wait_toggle(0, 100, n);
      check(n >= 4*3-4 && n <= 4*3-1, "R6", "first change after write", n, 4*3-1);
      wait_toggle(0, 100, n);
      check(n == 3*DIV, "R4", "half period H=3", n, 3*DIV);
      wait_toggle(0, 100, n);
      check(n == 3*DIV, "R7", "tick spacing gives half period", n, 3*DIV);
      check(led[3:1] == 3'b000, "R11", "other LEDs stay dark", led[3:1], 0);
      wb_write(2'd0, 32'h0000_0000);
   endtask

   task automatic t_half_zero();
      int n;
      wb_write(2'd3, 32'h0000_0002);
      wait_toggle(3, 3000, n);
      wait_toggle(3, 3000, n);
      check(n == DIV, "R5", "half period 0 acts as 1", n, DIV);
      wb_write(2'd3, 32'h0000_0000);
   endtask

   task automatic t_restart();
      int n;
      wb_write(2'd1, 32'h0000_0A02);
      wait_toggle(1, 200, n);
      repeat (24) @(negedge clk);
      wb_write(2'd1, 32'h0000_0A01);
      check(led[1] == 1'b1, "R3", "lit after mode change", led[1], 1);
      wb_write(2'd1, 32'h0000_0A02);
      check(led[1] == 1'b0, "R6", "flash restarts dark", led[1], 0);
      wait_toggle(1, 200, n);
      check(n >= 4*10-4 && n <= 4*10-1, "R6", "count restarted on mode change", n, 4*10-1);
      wb_write(2'd1, 32'h0000_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_on_off();
      t_readback();
      t_flash();
      t_half_zero();
      t_restart();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule